// File: doc/BRIEF.md
# Dual-Mode Parity / SEC-DED Memory Controller

This block sits between a host request port and a memory array of 36-bit words, each 32 data bits plus 4 protection bits. A mode input, sampled when a request is accepted, picks one of two behaviours. In parity mode every host access touches one memory word. Each data byte is guarded by its own odd parity bit. A read that fails parity cannot be located, so it raises a sticky halt-class error output.

In correction mode each host access touches an aligned pair of memory words. Together they carry a 64-bit datum and 8 check bits of an extended Hamming code: 7 position bits plus one overall parity bit. The 4 protection positions of each word hold half of the check byte. A read corrects any single flipped bit among the 72 stored bits and returns the corrected data in the normal response. A read with two flipped bits is flagged as uncorrectable. Corrected data is not written back.

Error events in both modes are counted in saturating counters, and the first event is captured in a sticky address/syndrome log. The log is released by a one-cycle clear pulse. The array behind the memory port has a one-cycle registered read.

Top module: `pecc_mem_ctrl`

## Requirements
- R1: After reset the block is idle with `req_ready` high. The block is in parity mode, `mem_en`, `rsp_valid`, `par_fatal` and `log_valid` are low, and both counters are zero.
- R2: A parity-mode write stores one word at `req_addr`, with data in bits 31:0 and, in bit 32+k, the odd parity bit of data byte k (the bit makes the byte plus its parity hold an odd number of ones). A clean parity-mode read returns the word's data in `rsp_rdata[31:0]`, with zeros above and no error flags.
- R3: A parity-mode read with an odd number of flips in some byte lane does the following. It sets `rsp_uncorr` and increments `ue_count`. It sets `par_fatal`, which stays high until reset.
- R4: A parity-mode read with two flips inside one lane, counting the lane's parity bit, is not detected. The flipped data is returned, no flag is raised and no counter or fatal output changes.
- R5: A correction-mode write ignores bit 0 of `req_addr`. It writes two memory words: the even address first, holding datum bits 31:0, then the odd address, holding bits 63:32. Check bits 3:0 go into bits 35:32 of the first word and check bits 7:4 into bits 35:32 of the second.
- R6: A correction-mode read with any single flipped bit among the 72 stored bits returns the original datum with `rsp_corrected` set and `rsp_uncorr` clear, and increments `ce_count`. The logged syndrome has bit 7 (overall parity mismatch) set.
- R7: A correction-mode read with any two flipped bits sets `rsp_uncorr`, leaves `rsp_corrected` clear and increments `ue_count`. The logged syndrome is nonzero with bit 7 clear.
- R8: A clean correction-mode read returns the written datum with both flags clear and leaves both counters unchanged.
- R9: The log captures the first-word address and syndrome of the first error event while `log_valid` is low, and holds them through later events. A `log_clr` pulse drops `log_valid`. A parity-mode syndrome is the 4-bit mask of failing lanes, zero-extended.
- R10: `ce_count` and `ue_count` stop at their all-ones value and never wrap.
- R11: `req_ready` is high only while idle, and the memory port is quiet then. `rsp_valid` is a single-cycle pulse per read, and both flags are low whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ecc_en | input | 1 | 1 selects correction mode, sampled at request acceptance |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Memory word address (bit 0 ignored in correction mode) |
| req_wdata | input | 64 | Write datum (bits 31:0 only in parity mode) |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 64 | Read datum |
| rsp_corrected | output | 1 | A single-bit error was corrected |
| rsp_uncorr | output | 1 | Uncorrectable error (parity fail or double error) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 36 | Memory write word |
| mem_rdata | input | 36 | Memory read word, one cycle after a read strobe |
| par_fatal | output | 1 | Sticky halt-class parity failure |
| ce_count | output | CNT_W | Saturating corrected-error count |
| ue_count | output | CNT_W | Saturating uncorrectable-error count |
| log_valid | output | 1 | Log holds an event |
| log_addr | output | ADDR_W | First-word address of the logged event |
| log_syndrome | output | 8 | Syndrome of the logged event |
| log_clr | input | 1 | Clear pulse for the log |

## Verification
Suppose the check bits are placed or computed wrongly. The next read of an untouched pair then shows corrected or uncorrectable flags, and the counters move, on the very first response. A wrong correction mask returns a datum that differs from the written one in the same response. Wrong per-lane parity shows immediately in the stored word at the array, and wrong counting is visible in the counter value one cycle after any error read. The single- and double-flip sweeps over all 72 bit positions cover every syndrome value that a one- or two-bit error can produce.

// File: rtl/pecc_pkg.sv
package pecc_pkg;
   localparam int unsigned WORD_DW   = 32;
   localparam int unsigned LANES     = WORD_DW / 8;
   localparam int unsigned MEM_W     = WORD_DW + LANES;
   localparam int unsigned WIDE_DW   = 2 * WORD_DW;
   localparam int unsigned HAM_W     = 7;
   localparam int unsigned CHK_W     = HAM_W + 1;
   localparam int unsigned CODE_LAST = WIDE_DW + HAM_W;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISS0,
      ST_ISS1,
      ST_LAST
   } ctl_state_e;

   // XOR of the code positions (powers of two excluded) of all set data bits
   function automatic logic [HAM_W-1:0] ham_fold(input logic [WIDE_DW-1:0] d);
      logic [HAM_W-1:0] acc;
      int unsigned k;
      acc = '0;
      k = 0;
      for (int unsigned p = 1; p <= CODE_LAST; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (d[k]) acc = acc ^ HAM_W'(p);
            k++;
         end
      end
      return acc;
   endfunction

   // one-hot data mask for a syndrome that points at a data position
   function automatic logic [WIDE_DW-1:0] ham_flip(input logic [HAM_W-1:0] s);
      logic [WIDE_DW-1:0] m;
      int unsigned k;
      m = '0;
      k = 0;
      for (int unsigned p = 1; p <= CODE_LAST; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (HAM_W'(p) == s) m[k] = 1'b1;
            k++;
         end
      end
      return m;
   endfunction
endpackage

// File: rtl/pecc_par_gen.sv
module pecc_par_gen #(
   parameter int unsigned DW = 32
) (
   input  logic [DW-1:0]   data_i,
   output logic [DW/8-1:0] par_o
);
   localparam int unsigned NLANE = DW / 8;

   if ((DW % 8) != 0 || DW == 0) begin : g_bad_dw
      $error("pecc_par_gen: DW must be a nonzero multiple of 8");
   end

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign par_o[g] = ~^data_i[8*g +: 8];
   end
endmodule

// File: rtl/pecc_sec_enc.sv
module pecc_sec_enc
   import pecc_pkg::*;
(
   input  logic [WIDE_DW-1:0] data_i,
   output logic [CHK_W-1:0]   chk_o
);
   logic [HAM_W-1:0] ham;

   always_comb begin
      ham   = ham_fold(data_i);
      chk_o = {(^data_i) ^ (^ham), ham};
   end
endmodule

// File: rtl/pecc_sec_dec.sv
module pecc_sec_dec
   import pecc_pkg::*;
(
   input  logic [WIDE_DW-1:0] data_i,
   input  logic [CHK_W-1:0]   chk_i,
   output logic [WIDE_DW-1:0] data_o,
   output logic [CHK_W-1:0]   syn_o,
   output logic               corr_o,
   output logic               uncorr_o
);
   logic [HAM_W-1:0] pos_syn;
   logic             ovr_mis;
   logic             in_range;

   always_comb begin
      pos_syn  = ham_fold(data_i) ^ chk_i[HAM_W-1:0];
      ovr_mis  = ^{data_i, chk_i};
      in_range = (32'(pos_syn) <= CODE_LAST);
      syn_o    = {ovr_mis, pos_syn};
      corr_o   = ovr_mis & in_range;
      uncorr_o = (syn_o != '0) & ~corr_o;
      data_o   = corr_o ? (data_i ^ ham_flip(pos_syn)) : data_i;
   end
endmodule

// File: rtl/pecc_err_log.sv
module pecc_err_log #(
   parameter int unsigned AW    = 10,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SYN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_ce,
   input  logic             ev_ue,
   input  logic [AW-1:0]    ev_addr,
   input  logic [SYN_W-1:0] ev_syn,
   input  logic             clr,
   output logic [CNT_W-1:0] ce_cnt,
   output logic [CNT_W-1:0] ue_cnt,
   output logic             log_vld,
   output logic [AW-1:0]    log_addr,
   output logic [SYN_W-1:0] log_syn
);
   localparam int unsigned   NCNT    = 2;
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [NCNT-1:0]  ev_vec;
   logic [CNT_W-1:0] cnt_q [NCNT];

   assign ev_vec = {ev_ue, ev_ce};

   for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q[g] <= '0;
         end else if (ev_vec[g] && cnt_q[g] != CNT_TOP) begin
            cnt_q[g] <= cnt_q[g] + 1'b1;
         end
      end
   end

   assign ce_cnt = cnt_q[0];
   assign ue_cnt = cnt_q[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         log_vld  <= 1'b0;
         log_addr <= '0;
         log_syn  <= '0;
      end else if ((|ev_vec) && (!log_vld || clr)) begin
         log_vld  <= 1'b1;
         log_addr <= ev_addr;
         log_syn  <= ev_syn;
      end else if (clr) begin
         log_vld  <= 1'b0;
      end
   end
endmodule

// File: rtl/pecc_mem_ctrl.sv
module pecc_mem_ctrl
   import pecc_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ecc_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [63:0]       req_wdata,
   output logic              rsp_valid,
   output logic [63:0]       rsp_rdata,
   output logic              rsp_corrected,
   output logic              rsp_uncorr,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [35:0]       mem_wdata,
   input  logic [35:0]       mem_rdata,
   output logic              par_fatal,
   output logic [CNT_W-1:0]  ce_count,
   output logic [CNT_W-1:0]  ue_count,
   output logic              log_valid,
   output logic [ADDR_W-1:0] log_addr,
   output logic [7:0]        log_syndrome,
   input  logic              log_clr
);
   localparam int unsigned SYN_W = CHK_W;
   localparam int unsigned PAD_W = SYN_W - LANES;

   if (ADDR_W < 2) begin : g_bad_aw
      $error("pecc_mem_ctrl: ADDR_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cw
      $error("pecc_mem_ctrl: CNT_W must be at least 1");
   end
   if (MEM_W != 36 || WIDE_DW != 64) begin : g_bad_geom
      $error("pecc_mem_ctrl: word geometry does not match the ports");
   end

   ctl_state_e          st_q, st_d;
   logic                op_we_q, op_ecc_q;
   logic [ADDR_W-1:0]   op_addr_q;
   logic [WIDE_DW-1:0]  op_wdata_q;
   logic [MEM_W-1:0]    lo_word_q;
   logic                accept, in_last;

   logic [CHK_W-1:0]    wr_chk;
   logic [LANES-1:0]    wr_par, rd_par, rd_mis;
   logic [WIDE_DW-1:0]  dec_data;
   logic [CHK_W-1:0]    dec_syn;
   logic                dec_corr, dec_uncorr;
   logic                ev_ce, ev_ue;
   logic [SYN_W-1:0]    ev_syn;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid & req_ready;
   assign in_last   = (st_q == ST_LAST);

   // ---------------- sequencing ----------------
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (accept) st_d = ST_ISS0;
         ST_ISS0: st_d = op_ecc_q ? ST_ISS1 : (op_we_q ? ST_IDLE : ST_LAST);
         ST_ISS1: st_d = op_we_q ? ST_IDLE : ST_LAST;
         ST_LAST: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         op_we_q    <= 1'b0;
         op_ecc_q   <= 1'b0;
         op_addr_q  <= '0;
         op_wdata_q <= '0;
         lo_word_q  <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            op_we_q    <= req_we;
            op_ecc_q   <= cfg_ecc_en;
            op_addr_q  <= cfg_ecc_en ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
            op_wdata_q <= req_wdata;
         end
         if (st_q == ST_ISS1) lo_word_q <= mem_rdata;
      end
   end

   // ---------------- write path ----------------
   pecc_sec_enc i_enc (
      .data_i (op_wdata_q),
      .chk_o  (wr_chk)
   );

   pecc_par_gen #(.DW(WORD_DW)) i_par_wr (
      .data_i (op_wdata_q[WORD_DW-1:0]),
      .par_o  (wr_par)
   );

   assign mem_en   = (st_q == ST_ISS0) || (st_q == ST_ISS1);
   assign mem_we   = mem_en & op_we_q;
   assign mem_addr = {op_addr_q[ADDR_W-1:1], op_addr_q[0] | (st_q == ST_ISS1)};

   always_comb begin
      if (st_q == ST_ISS1)
         mem_wdata = {wr_chk[CHK_W-1:LANES], op_wdata_q[WIDE_DW-1:WORD_DW]};
      else if (op_ecc_q)
         mem_wdata = {wr_chk[LANES-1:0], op_wdata_q[WORD_DW-1:0]};
      else
         mem_wdata = {wr_par, op_wdata_q[WORD_DW-1:0]};
   end

   // ---------------- read path ----------------
   pecc_par_gen #(.DW(WORD_DW)) i_par_rd (
      .data_i (mem_rdata[WORD_DW-1:0]),
      .par_o  (rd_par)
   );
   assign rd_mis = rd_par ^ mem_rdata[MEM_W-1:WORD_DW];

   pecc_sec_dec i_dec (
      .data_i   ({mem_rdata[WORD_DW-1:0], lo_word_q[WORD_DW-1:0]}),
      .chk_i    ({mem_rdata[MEM_W-1:WORD_DW], lo_word_q[MEM_W-1:WORD_DW]}),
      .data_o   (dec_data),
      .syn_o    (dec_syn),
      .corr_o   (dec_corr),
      .uncorr_o (dec_uncorr)
   );

   assign ev_ce  = in_last & op_ecc_q & dec_corr;
   assign ev_ue  = in_last & (op_ecc_q ? dec_uncorr : (|rd_mis));
   assign ev_syn = op_ecc_q ? dec_syn : {{PAD_W{1'b0}}, rd_mis};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_rdata     <= '0;
         rsp_corrected <= 1'b0;
         rsp_uncorr    <= 1'b0;
         par_fatal     <= 1'b0;
      end else begin
         rsp_valid     <= in_last;
         rsp_corrected <= ev_ce;
         rsp_uncorr    <= ev_ue;
         if (in_last)
            rsp_rdata <= op_ecc_q ? dec_data : {{WORD_DW{1'b0}}, mem_rdata[WORD_DW-1:0]};
         if (in_last && !op_ecc_q && (|rd_mis))
            par_fatal <= 1'b1;
      end
   end

   // ---------------- event recording ----------------
   pecc_err_log #(.AW(ADDR_W), .CNT_W(CNT_W), .SYN_W(SYN_W)) i_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_ce    (ev_ce),
      .ev_ue    (ev_ue),
      .ev_addr  (op_addr_q),
      .ev_syn   (ev_syn),
      .clr      (log_clr),
      .ce_cnt   (ce_count),
      .ue_cnt   (ue_count),
      .log_vld  (log_valid),
      .log_addr (log_addr),
      .log_syn  (log_syndrome)
   );
endmodule

// File: rtl/pecc_mem_ctrl_chk.sv
module pecc_mem_ctrl_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              mem_en,
   input logic              rsp_valid,
   input logic              rsp_corrected,
   input logic              rsp_uncorr,
   input logic              par_fatal,
   input logic [CNT_W-1:0]  ce_count,
   input logic [CNT_W-1:0]  ue_count,
   input logic              log_valid,
   input logic              log_clr,
   input logic [ADDR_W-1:0] log_addr,
   input logic [7:0]        log_syndrome
);
   localparam logic [CNT_W-1:0] TOP = '1;

   AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      par_fatal |=> par_fatal); // R3
   AST_CE_ONLY_CORRECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_count != $past(ce_count)) |-> (rsp_valid && rsp_corrected)); // R6
   AST_UE_ONLY_UNCORR: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_count != $past(ue_count)) |-> (rsp_valid && rsp_uncorr)); // R7
   AST_CE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_count == TOP) |=> (ce_count == TOP)); // R10
   AST_UE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_count == TOP) |=> (ue_count == TOP)); // R10
   AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (log_valid && !log_clr) |=> (log_valid && $stable(log_addr) && $stable(log_syndrome))); // R9
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_corrected && rsp_uncorr)); // R6
   AST_FLAGS_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_corrected && !rsp_uncorr)); // R11
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_en); // R11
endmodule

bind pecc_mem_ctrl pecc_mem_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .mem_en        (mem_en),
   .rsp_valid     (rsp_valid),
   .rsp_corrected (rsp_corrected),
   .rsp_uncorr    (rsp_uncorr),
   .par_fatal     (par_fatal),
   .ce_count      (ce_count),
   .ue_count      (ue_count),
   .log_valid     (log_valid),
   .log_clr       (log_clr),
   .log_addr      (log_addr),
   .log_syndrome  (log_syndrome)
);

// File: tb/test_pecc_mem_ctrl.sv
module test_pecc_mem_ctrl;
   localparam int AW      = 10;
   localparam int CW      = 8;
   localparam int CNT_MAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_ecc_en = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [63:0]   req_wdata = '0;
   logic          rsp_valid;
   logic [63:0]   rsp_rdata;
   logic          rsp_corrected, rsp_uncorr;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [35:0]   mem_wdata, mem_rdata;
   logic          par_fatal;
   logic [CW-1:0] ce_count, ue_count;
   logic          log_valid;
   logic [AW-1:0] log_addr;
   logic [7:0]    log_syndrome;
   logic          log_clr = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   pecc_mem_ctrl #(.ADDR_W(AW), .CNT_W(CW)) i_pecc_mem_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_corrected(rsp_corrected), .rsp_uncorr(rsp_uncorr),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .par_fatal(par_fatal), .ce_count(ce_count), .ue_count(ue_count),
      .log_valid(log_valid), .log_addr(log_addr), .log_syndrome(log_syndrome),
      .log_clr(log_clr)
   );

   // behavioural array with read-path fault injection
   logic [35:0]   mem [1 << AW];
   logic [35:0]   mem_rd_q = '0;
   logic [AW-1:0] fa_addr = '0, fb_addr = '0;
   logic [35:0]   fa_mask = '0, fb_mask = '0;

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else mem_rd_q <= mem[mem_addr]
                         ^ ((mem_addr == fa_addr) ? fa_mask : 36'h0)
                         ^ ((mem_addr == fb_addr) ? fb_mask : 36'h0);
      end
   end
   assign mem_rdata = mem_rd_q;

   logic [63:0] got_data;
   logic        got_corr, got_unc;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      int t = 0;
      while (!req_ready && t < 100) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic host_write(input int a, input logic [63:0] d);
      @(negedge clk);
      wait_idle();
      req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
      wait_idle();
   endtask

   task automatic host_read(input int a);
      int t = 0;
      @(negedge clk);
      wait_idle();
      req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid && t < 100) begin
         @(negedge clk);
         t++;
      end
      got_data = rsp_rdata;
      got_corr = rsp_corrected;
      got_unc  = rsp_uncorr;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      log_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_reset_state(input string tag);
      check(req_ready === 1'b1 && mem_en === 1'b0 && rsp_valid === 1'b0, tag, {61'h0, req_ready, mem_en, rsp_valid}, 64'h4);
      check(par_fatal === 1'b0 && log_valid === 1'b0, tag, {62'h0, par_fatal, log_valid}, 64'h0);
      check(ce_count === '0 && ue_count === '0, tag, {48'h0, ce_count, ue_count}, 64'h0);
   endtask

   function automatic logic [35:0] par_word(input logic [31:0] d);
      logic [3:0] p;
      for (int k = 0; k < 4; k++) p[k] = ~^d[8*k +: 8];
      return {p, d};
   endfunction

   // stored bit b of a pair: 0..63 datum, 64..71 check
   function automatic void ecc_loc(input int b, output int w, output int pos);
      if (b < 32)      begin w = 0; pos = b;      end
      else if (b < 64) begin w = 1; pos = b - 32; end
      else if (b < 68) begin w = 0; pos = b - 32; end
      else             begin w = 1; pos = b - 36; end
   endfunction

   task automatic add_flip(input int b);
      int w, pos;
      ecc_loc(b, w, pos);
      if (w == 0) fa_mask = fa_mask | (36'h1 << pos);
      else        fb_mask = fb_mask | (36'h1 << pos);
   endtask

   function automatic int lane_bit(input int lane, input int i);
      return (i < 8) ? (8*lane + i) : (32 + lane);
   endfunction

   function automatic int sat(input int n);
      return (n > CNT_MAX) ? CNT_MAX : n;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d32;
      logic [63:0] pat [4];
      int n;
      pat[0] = 64'h0;
      pat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pat[2] = 64'hA5A5_0F0F_3C3C_9696;
      pat[3] = 64'h8000_0000_0000_0001;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("R1");

      // ---- parity mode: storage layout and clean read-back (R2)
      for (int a = 0; a < 16; a++) begin
         d32 = 32'h1357_9BDF ^ (32'(a) * 32'h0102_0408);
         host_write(a, {32'hDEAD_BEEF, d32});
         check(mem[a] === par_word(d32), "R2 stored word", {28'h0, mem[a]}, {28'h0, par_word(d32)});
         host_read(a);
         check(got_data === {32'h0, d32} && !got_corr && !got_unc, "R2 read-back",
               got_data, {32'h0, d32});
      end

      // ---- two flips inside one lane go unseen (R4)
      d32 = 32'h6C1E_94F3;
      host_write(5, {32'h0, d32});
      fa_addr = AW'(5); fb_mask = '0;
      for (int lane = 0; lane < 4; lane++) begin
         for (int i = 0; i < 9; i++) begin
            for (int j = i + 1; j < 9; j++) begin
               fa_mask = (36'h1 << lane_bit(lane, i)) | (36'h1 << lane_bit(lane, j));
               host_read(5);
               check(got_data === {32'h0, d32 ^ fa_mask[31:0]}, "R4 data passes flipped",
                     got_data, {32'h0, d32 ^ fa_mask[31:0]});
               check(!got_unc && !par_fatal && ue_count === '0, "R4 no detection",
                     {61'h0, got_unc, par_fatal, |ue_count}, 64'h0);
            end
         end
      end

      // ---- single flips are fatal (R3), log keeps the first (R9)
      for (int b = 0; b < 36; b++) begin
         fa_mask = 36'h1 << b;
         host_read(5);
         check(got_unc === 1'b1 && !got_corr && par_fatal === 1'b1, "R3 flip detected",
               {61'h0, got_unc, got_corr, par_fatal}, 64'h5);
         check(ue_count === CW'(b + 1), "R3 ue count", 64'(ue_count), 64'(b + 1));
         if (b == 0)
            check(log_valid && log_addr === AW'(5) && log_syndrome === 8'h01, "R9 first parity log",
                  {log_valid, 45'h0, log_addr, log_syndrome}, {1'b1, 45'h0, AW'(5), 8'h01});
      end
      fa_addr = AW'(3); fa_mask = 36'h1 << 35;
      host_write(3, 64'h1234_5678);
      host_read(3);
      check(log_addr === AW'(5) && log_syndrome === 8'h01, "R9 log held",
            {48'h0, 6'h0, log_addr}, 64'(5));
      pulse_clr();
      check(log_valid === 1'b0, "R9 clear", 64'(log_valid), 64'h0);
      host_read(3);
      check(log_valid && log_addr === AW'(3) && log_syndrome === 8'h08, "R9 new capture",
            {log_valid, 45'h0, log_addr, log_syndrome}, {1'b1, 45'h0, AW'(3), 8'h08});
      check(par_fatal === 1'b1 && ue_count === CW'(38), "R3 fatal held",
            {55'h0, par_fatal, ue_count}, {55'h0, 1'b1, CW'(38)});
      fa_mask = '0;

      do_reset();
      check_reset_state("R1 after reset");

      // ---- correction mode layout (R5) and clean read (R8)
      cfg_ecc_en = 1'b1;
      host_write(9, 64'h0123_4567_89AB_CDEF);
      check(mem[8][31:0] === 32'h89AB_CDEF && mem[9][31:0] === 32'h0123_4567, "R5 pair layout",
            {mem[9][31:0], mem[8][31:0]}, 64'h0123_4567_89AB_CDEF);
      host_read(8);
      check(got_data === 64'h0123_4567_89AB_CDEF && !got_corr && !got_unc, "R8 clean read",
            got_data, 64'h0123_4567_89AB_CDEF);
      check(ce_count === '0 && ue_count === '0, "R8 counters still", {48'h0, ce_count, ue_count}, 64'h0);

      // ---- all 72 single flips, four patterns (R6, R10)
      n = 0;
      for (int p = 0; p < 4; p++) begin
         host_write(20 + 2*p, pat[p]);
         host_read(20 + 2*p);
         check(got_data === pat[p] && !got_corr && !got_unc, "R8 clean pattern", got_data, pat[p]);
         fa_addr = AW'(20 + 2*p); fb_addr = AW'(21 + 2*p);
         for (int b = 0; b < 72; b++) begin
            fa_mask = '0; fb_mask = '0;
            add_flip(b);
            host_read(20 + 2*p);
            n++;
            check(got_data === pat[p] && got_corr === 1'b1 && got_unc === 1'b0, "R6 corrected",
                  got_data, pat[p]);
            check(ce_count === CW'(sat(n)), "R10 ce count", 64'(ce_count), 64'(sat(n)));
            if (n == 1)
               check(log_valid && log_addr === AW'(20) && log_syndrome[7] === 1'b1, "R6 single log",
                     {log_valid, 45'h0, log_addr, log_syndrome}, {1'b1, 45'h0, AW'(20), 8'h80});
         end
      end
      fa_mask = '0; fb_mask = '0;
      check(ce_count === CW'(CNT_MAX), "R10 ce saturated", 64'(ce_count), 64'(CNT_MAX));

      // ---- all pairs of flips (R7, R10)
      pulse_clr();
      host_write(40, pat[2]);
      fa_addr = AW'(40); fb_addr = AW'(41);
      n = 0;
      for (int i = 0; i < 72; i++) begin
         for (int j = i + 1; j < 72; j++) begin
            fa_mask = '0; fb_mask = '0;
            add_flip(i);
            add_flip(j);
            host_read(40);
            n++;
            check(got_unc === 1'b1 && got_corr === 1'b0, "R7 double flagged",
                  {62'h0, got_unc, got_corr}, 64'h2);
            check(ue_count === CW'(sat(n)), "R10 ue count", 64'(ue_count), 64'(sat(n)));
            if (n == 1)
               check(log_valid && log_addr === AW'(40) && log_syndrome[7] === 1'b0 && log_syndrome != 8'h0,
                     "R7 double log", {log_valid, 45'h0, log_addr, log_syndrome}, {1'b1, 45'h0, AW'(40), 8'h7F});
         end
      end
      fa_mask = '0; fb_mask = '0;
      host_read(40);
      check(got_data === pat[2] && !got_corr && !got_unc, "R8 clean after sweep", got_data, pat[2]);
      check(ce_count === CW'(CNT_MAX) && ue_count === CW'(CNT_MAX), "R10 both held at top",
            {48'h0, ce_count, ue_count}, {48'h0, CW'(CNT_MAX), CW'(CNT_MAX)});
      check(req_ready === 1'b1 && mem_en === 1'b0, "R11 idle quiet", {62'h0, req_ready, mem_en}, 64'h2);

      summary();
      $finish;
   end
endmodule